// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block turns a fast reference clock into the serial clock and active-low select lines for a serial flash device. A transfer engine requests a transfer. The generator then asserts the chosen select, waits a programmable lead-in, and toggles the serial clock at a programmable rate. It pulses a sample strobe and a shift strobe on the matching clock edges, so the engine knows when to capture and when to launch data bits. It stops only at the end of a whole clock period, holds the select for a programmable tail, and then enforces a minimum deselect time before it accepts the next request.

The configuration inputs act as static register fields. They are changed only while the enable input is low. They set:
- the clock rest level and the capture phase;
- a divider, so that the serial clock period is 2×(divider+1) reference clocks;
- a select field, used either as an index that picks one line of a one-hot group or, in decoder mode, driven out unchanged;
- four delays, each counted in reference clocks.

Top module: `sclk_cs_timer`

## Requirements
- R1: While clocking, consecutive serial clock edges are exactly `cfg_baud`+1 reference clocks apart, which gives a period of 2×(`cfg_baud`+1).
- R2: When no clocking is in progress, `sclk` rests at `cfg_cpol`, including while the block is disabled. A leading edge moves `sclk` away from that level.
- R3: Each serial clock edge raises exactly one strobe, in the same cycle as the edge. With `cfg_cpha`=0 the leading edge raises `sample_stb` and the trailing edge raises `shift_stb`; with `cfg_cpha`=1 the two are swapped. No strobe occurs between edges.
- R4: With `cfg_decode`=0, a select value n below 4 drives `cs_n` with bit n low and all other bits high (n=0 gives 4'b1110, n=3 gives 4'b0111). A value of 4 or more drives no bit low, but the transfer still runs.
- R5: With `cfg_decode`=1, `cs_n` carries `cfg_cs_field` unchanged for the whole transfer.
- R6: The first serial clock edge follows select assertion by `cfg_lead_dly` + `cfg_baud` + 2 reference clocks.
- R7: `req_stop` is sampled only at trailing edges, so every transfer has a whole number of clock periods. The select deasserts `cfg_trail_dly` + 2×(`cfg_baud`+1) + 3 reference clocks after the last edge.
- R8: After the select deasserts, a new transfer cannot assert it for `cfg_desel_dly` + 2×(`cfg_baud`+1) + 1 reference clocks. A request that is held starts exactly then.
- R9: If the next select pattern differs from the previous one, `cfg_switch_dly` further reference clocks are added to the R8 time.
- R10: While `cfg_enable` is low, requests are ignored. Dropping the enable during a transfer aborts it: on the next cycle `cs_n` is all ones and `idle` is high.
- R11: `idle` is low exactly from the cycle the select asserts up to the cycle it deasserts.
- R12: During reset, `cs_n` is all ones, `sclk` is low and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable; configuration changes only while low |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_baud | input | 4 | Divider; half period = value+1 reference clocks |
| cfg_cs_field | input | 4 | Select index, or raw select code in decoder mode |
| cfg_decode | input | 1 | 1: drive the select field out unchanged |
| cfg_lead_dly | input | 8 | Extra clocks from select low to first edge |
| cfg_trail_dly | input | 8 | Extra clocks from last edge to select high |
| cfg_desel_dly | input | 8 | Extra minimum select-high clocks |
| cfg_switch_dly | input | 8 | Added select-high clocks when the device changes |
| req_start | input | 1 | Level request to begin a transfer |
| req_stop | input | 1 | Level request to end at the next trailing edge |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low select lines or select code |
| sample_stb | output | 1 | Pulse on the capture edge |
| shift_stb | output | 1 | Pulse on the launch edge |
| idle | output | 1 | High when no transfer is active |

## Verification
The assertions assume that the configuration fields, `cfg_cpol` in particular, stay constant while `cfg_enable` is high. The rest-level and hold-phase properties compare `sclk` with the live polarity input. The stimulus keeps to this. Every configuration change, including the select change between back-to-back transfers, is made inside a window where the enable is low. `req_stop` is raised only after the leading edge of the final period has been seen and is cleared when the select deasserts, so the stop request never reaches a trailing edge of a later transfer.

// File: rtl/sctg_pkg.sv
package sctg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CLK   = 2'd2,
    ST_HOLD  = 2'd3
  } sctg_state_e;

endpackage

// File: rtl/sctg_cs_map.sv
module sctg_cs_map #(
  parameter int CS_W = 4
) (
  input  logic [CS_W-1:0] sel,
  input  logic            dec_en,
  output logic [CS_W-1:0] pat
);

  // One line per output bit: raw code in decoder mode, else active-low one-hot.
  for (genvar i = 0; i < CS_W; i++) begin : g_line
    assign pat[i] = dec_en ? sel[i] : (sel != CS_W'(i));
  end

endmodule

// File: rtl/sctg_clkdiv.sv
module sctg_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] baud,
  output logic             sclk,
  output logic             edge_now,
  output logic             lead_now,
  output logic             sample_stb,
  output logic             shift_stb
);

  logic [DIV_W-1:0] hc;
  logic             lead_q;

  assign edge_now = run && (hc == baud);
  assign lead_now = lead_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc         <= '0;
      lead_q     <= 1'b1;
      sclk       <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      sample_stb <= edge_now && (lead_q ^ cpha);
      shift_stb  <= edge_now && !(lead_q ^ cpha);
      if (!run) begin
        hc     <= '0;
        lead_q <= 1'b1;
        sclk   <= cpol;
      end else if (edge_now) begin
        hc     <= '0;
        lead_q <= !lead_q;
        sclk   <= !sclk;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  a_r2_rest_level: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(cpol)));

  a_r1_no_toggle_between_edges: assert property (@(posedge clk) disable iff (rst)
    (run && !edge_now) |=> $stable(sclk));

  a_r3_edge_gives_strobe: assert property (@(posedge clk) disable iff (rst)
    edge_now |=> ((sample_stb || shift_stb) && (sclk != $past(sclk))));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && shift_stb));

endmodule

// File: rtl/sctg_gap_guard.sv
module sctg_gap_guard #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int GAP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_idle,
  input  logic             restart,
  input  logic [DIV_W-1:0] baud,
  input  logic [DLY_W-1:0] desel_dly,
  input  logic [DLY_W-1:0] switch_dly,
  input  logic             dev_change,
  output logic             ok
);

  localparam logic [GAP_W-1:0] SAT = '1;

  logic [GAP_W-1:0] since;
  logic [GAP_W-1:0] need;

  // Minimum select-high time: programmed count + one serial period + one clock.
  always_comb begin
    need = GAP_W'(desel_dly) + (GAP_W'(baud) << 1) + GAP_W'(3);
    if (dev_change) need = need + GAP_W'(switch_dly);
  end

  assign ok = (since >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= SAT;
    end else if (restart) begin
      since <= GAP_W'(1);
    end else if (in_idle && (since != SAT)) begin
      since <= since + 1'b1;
    end
  end

  a_r8_counter_saturates: assert property (@(posedge clk) disable iff (rst)
    (in_idle && !restart && (since == SAT)) |=> (since == SAT));

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> !ok);

endmodule

// File: rtl/sclk_cs_timer.sv
module sclk_cs_timer
  import sctg_pkg::*;
#(
  parameter int CS_W  = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_baud,
  input  logic [CS_W-1:0]  cfg_cs_field,
  input  logic             cfg_decode,
  input  logic [DLY_W-1:0] cfg_lead_dly,
  input  logic [DLY_W-1:0] cfg_trail_dly,
  input  logic [DLY_W-1:0] cfg_desel_dly,
  input  logic [DLY_W-1:0] cfg_switch_dly,
  input  logic             req_start,
  input  logic             req_stop,
  output logic             sclk,
  output logic [CS_W-1:0]  cs_n,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             idle
);

  localparam int BASE_W = (DLY_W > DIV_W + 1) ? DLY_W : DIV_W + 1;
  localparam int CNT_W  = BASE_W + 2;

  sctg_state_e      st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CS_W-1:0]  cs_q, cs_nx, last_pat, last_pat_n, pat;
  logic             idle_q, restart, gap_ok, edge_now, lead_now, run;

  assign run = (st == ST_CLK);

  sctg_cs_map #(.CS_W(CS_W)) u_map (
    .sel    (cfg_cs_field),
    .dec_en (cfg_decode),
    .pat    (pat)
  );

  sctg_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cpol       (cfg_cpol),
    .cpha       (cfg_cpha),
    .baud       (cfg_baud),
    .sclk       (sclk),
    .edge_now   (edge_now),
    .lead_now   (lead_now),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb)
  );

  sctg_gap_guard #(.DIV_W(DIV_W), .DLY_W(DLY_W), .GAP_W(CNT_W)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .in_idle    (st == ST_IDLE),
    .restart    (restart),
    .baud       (cfg_baud),
    .desel_dly  (cfg_desel_dly),
    .switch_dly (cfg_switch_dly),
    .dev_change (pat != last_pat),
    .ok         (gap_ok)
  );

  always_comb begin
    st_n       = st;
    cnt_n      = cnt;
    cs_nx      = cs_q;
    last_pat_n = last_pat;
    restart    = 1'b0;
    if (!cfg_enable) begin
      st_n    = ST_IDLE;
      cs_nx   = '1;
      restart = (st != ST_IDLE);
    end else begin
      unique case (st)
        ST_IDLE: begin
          cs_nx = '1;
          if (req_start && gap_ok) begin
            st_n       = ST_SETUP;
            cnt_n      = CNT_W'(cfg_lead_dly);
            cs_nx      = pat;
            last_pat_n = pat;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) st_n = ST_CLK;
          else           cnt_n = cnt - CNT_W'(1);
        end
        ST_CLK: begin
          // Stop only on a trailing edge so that whole periods are sent.
          if (edge_now && !lead_now && req_stop) begin
            st_n  = ST_HOLD;
            cnt_n = CNT_W'(cfg_trail_dly) + (CNT_W'(cfg_baud) << 1) + CNT_W'(4);
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            st_n    = ST_IDLE;
            cs_nx   = '1;
            restart = 1'b1;
          end else begin
            cnt_n = cnt - CNT_W'(1);
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cs_q     <= '1;
      last_pat <= '1;
      idle_q   <= 1'b1;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      cs_q     <= cs_nx;
      last_pat <= last_pat_n;
      idle_q   <= (st_n == ST_IDLE);
    end
  end

  assign cs_n = cs_q;
  assign idle = idle_q;

  a_r10_disable_releases: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> ((cs_n == '1) && idle));

  a_r8_guard_blocks_start: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && !gap_ok) |=> (st == ST_IDLE));

  a_r11_select_implies_busy: assert property (@(posedge clk) disable iff (rst)
    (cs_n != '1) |-> !idle);

  a_r7_hold_at_rest: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> (sclk == cfg_cpol));

  a_r6_setup_at_rest: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETUP) |-> (sclk == cfg_cpol));

endmodule

// File: tb/sim_sclk_cs_timer.sv
module sim_sclk_cs_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, cpol = 1'b0, cpha = 1'b0, dec = 1'b0;
  logic [3:0] baud = '0, sel = '0;
  logic [7:0] su = '0, ho = '0, de = '0, ga = '0;
  logic       req_start = 1'b0, req_stop = 1'b0;
  logic       sclk, sample_stb, shift_stb, idle;
  logic [3:0] cs_n;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sclk_cs_timer u0 (
    .clk(clk), .rst(rst), .cfg_enable(en), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_baud(baud), .cfg_cs_field(sel), .cfg_decode(dec),
    .cfg_lead_dly(su), .cfg_trail_dly(ho), .cfg_desel_dly(de), .cfg_switch_dly(ga),
    .req_start(req_start), .req_stop(req_stop),
    .sclk(sclk), .cs_n(cs_n), .sample_stb(sample_stb), .shift_stb(shift_stb), .idle(idle)
  );

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [3:0] baud;
    logic       dec;
    logic [3:0] sa;
    logic [3:0] sb;
    logic [7:0] su;
    logic [7:0] ho;
    logic [7:0] de;
    logic [7:0] ga;
    logic [3:0] np;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd0,  1'b0, 4'd0, 4'd1, 8'd0,   8'd0,   8'd0,   8'd5,   4'd2},
    '{1'b1, 1'b0, 4'd1,  1'b0, 4'd2, 4'd2, 8'd3,   8'd2,   8'd4,   8'd9,   4'd3},
    '{1'b0, 1'b1, 4'd3,  1'b0, 4'd3, 4'd0, 8'd1,   8'd5,   8'd2,   8'd7,   4'd1},
    '{1'b1, 1'b1, 4'd2,  1'b1, 4'd5, 4'd9, 8'd2,   8'd1,   8'd6,   8'd3,   4'd2},
    '{1'b0, 1'b0, 4'd15, 1'b1, 4'd7, 4'd7, 8'd10,  8'd10,  8'd10,  8'd10,  4'd1},
    '{1'b1, 1'b1, 4'd0,  1'b0, 4'd1, 4'd3, 8'd200, 8'd100, 8'd150, 8'd200, 4'd4}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_pat(input int d, input int s);
    if (d != 0) return s;
    if (s < 4) return 15 & ~(1 << s);
    return 15;
  endfunction

  // Runs one transfer (req_start already high) and checks its timing.
  task automatic run_one(input vec_t v, input int pat, output int t_cs, output int t_up);
    int   edges, t_prev, t_first, bad_int, bad_stb, nsamp;
    logic prev_s, lead;
    do @(negedge clk); while (idle);
    t_cs = cyc;
    chk(v.dec ? "R5 decoded select" : "R4 one-hot select", int'(cs_n), pat);
    chk("R2 rest level at select", int'(sclk), int'(v.cpol));
    prev_s = sclk; edges = 0; t_prev = t_cs; t_first = t_cs;
    bad_int = 0; bad_stb = 0; nsamp = 0;
    forever begin
      @(negedge clk);
      if (idle) break;
      if (sclk !== prev_s) begin
        edges++;
        if (edges == 1) t_first = cyc;
        else if (cyc - t_prev != int'(v.baud) + 1) bad_int++;
        lead = (sclk != v.cpol);
        if (sample_stb !== (lead ^ v.cpha) || shift_stb !== !(lead ^ v.cpha)) bad_stb++;
        if (sample_stb) nsamp++;
        t_prev = cyc; prev_s = sclk;
        if (edges >= 2 * int'(v.np) - 1) req_stop = 1'b1;
      end else if (sample_stb || shift_stb) begin
        bad_stb++;
      end
    end
    t_up = cyc;
    req_stop = 1'b0;
    chk("R6 select to first edge", t_first - t_cs, int'(v.su) + int'(v.baud) + 2);
    chk("R7 whole periods", edges, 2 * int'(v.np));
    chk("R7 last edge to deselect", t_up - t_prev, int'(v.ho) + 2 * (int'(v.baud) + 1) + 3);
    chk("R2 rest level after transfer", int'(sclk), int'(v.cpol));
    chk("R1 edge spacing errors", bad_int, 0);
    chk("R3 strobe errors", bad_stb, 0);
    chk("R3 sample count", nsamp, int'(v.np));
    chk("R11 select released with idle", int'(cs_n), 15);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int tc1, tu1, tc2, tu2, pa, pb, need, bad;
    repeat (3) @(negedge clk);
    chk("R12 reset select", int'(cs_n), 15);
    chk("R12 reset sclk", int'(sclk), 0);
    chk("R12 reset idle", int'(idle), 1);
    rst = 1'b0;

    // Vector table: two back-to-back transfers per entry.
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      @(negedge clk);
      en = 1'b0;
      cpol = v.cpol; cpha = v.cpha; baud = v.baud; dec = v.dec; sel = v.sa;
      su = v.su; ho = v.ho; de = v.de; ga = v.ga;
      @(negedge clk);
      en = 1'b1;
      repeat (600) @(negedge clk);
      pa = exp_pat(int'(v.dec), int'(v.sa));
      pb = exp_pat(int'(v.dec), int'(v.sb));
      req_start = 1'b1;
      run_one(v, pa, tc1, tu1);
      en = 1'b0; sel = v.sb;
      @(negedge clk);
      en = 1'b1;
      run_one(v, pb, tc2, tu2);
      req_start = 1'b0;
      need = int'(v.de) + 2 * (int'(v.baud) + 1) + 1 + ((pa != pb) ? int'(v.ga) : 0);
      chk((pa != pb) ? "R9 device switch gap" : "R8 deselect minimum", tc2 - tu1, need);
    end

    // R10: requests ignored while disabled.
    @(negedge clk);
    en = 1'b0; cpol = 1'b1; req_start = 1'b1; bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (cs_n != 4'hF || !idle) bad++;
    end
    req_start = 1'b0;
    chk("R10 start ignored when disabled", bad, 0);
    chk("R2 rest level follows polarity when disabled", int'(sclk), 1);

    // R4: out-of-range index in one-hot mode asserts no line.
    cpol = 1'b0; cpha = 1'b0; baud = 4'd1; dec = 1'b0; sel = 4'd6;
    su = 8'd2; ho = 8'd2; de = 8'd2; ga = 8'd0;
    @(negedge clk);
    en = 1'b1;
    repeat (600) @(negedge clk);
    req_start = 1'b1; req_stop = 1'b1;
    do @(negedge clk); while (idle);
    req_start = 1'b0;
    chk("R4 index 6 asserts no line", int'(cs_n), 15);
    do @(negedge clk); while (!idle);
    req_stop = 1'b0;
    chk("R4 transfer with index 6 completes", int'(cs_n), 15);

    // R10: abort by dropping the enable during the lead-in.
    @(negedge clk);
    en = 1'b0; sel = 4'd1; su = 8'd200;
    @(negedge clk);
    en = 1'b1;
    repeat (600) @(negedge clk);
    req_start = 1'b1;
    do @(negedge clk); while (idle);
    req_start = 1'b0;
    chk("R11 idle low while selected", int'(cs_n), 13);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R10 abort releases select", int'(cs_n), 15);
    chk("R10 abort raises idle", int'(idle), 1);
    chk("R10 abort leaves sclk at rest", int'(sclk), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule